// File: doc/BRIEF.md
# Interlace-capable raster timing generator

The block drives the horizontal sync, vertical sync, data-enable and field-identifier signals for one display channel. It runs on the pixel clock, so one clock is one pixel. A single-cycle write port sets up the timing. Every horizontal and vertical size is written as its count minus one. Interlaced scan has its own register for the second field's vertical values and its own register for that field's active height.

Each line runs in this order: active pixels, front porch, sync, back porch. Each field or frame runs the same way in lines. Timing values and the scan mode are kept in a pending set. That set is copied into the working set only at the end of a frame, or at any time while the generator is off. A frame in progress therefore never mixes old and new values. The start of every vertical sync sets a frame-event status bit. The interrupt output is that status bit gated by a mask, and a write of one clears the status.

Top module: `raster_timing_gen`

## Requirements
- R1: `de` is high only while the pixel column is below ACT[9:0]+1 and the line is below the current field's active height. The frame or first-field height is ACT[19:10]+1, and the second-field height is F2ACT (address 4) bits [9:0] plus 1. ACT is at address 0. Column 0 of line 0 is the first active pixel.
- R2: A line has HACT+1 active pixels, then HFP+1 front-porch pixels, then HSW+1 sync pixels, then HBP+1 back-porch pixels. HTIM is at address 1, with HSW in [9:0], HBP in [19:10] and HFP in [29:20]. The internal hsync is active only during the sync pixels.
- R3: The vertical layout of a progressive frame, or of the first field, follows the same order and minus-one coding in lines. It comes from V1TIM at address 2, which uses the HTIM field layout. Vsync starts and ends at column 0 of a line.
- R4: In interlaced scan the first field is followed by the second field. Each field uses its own active height and vertical timing. The vertical timing of the second field comes from V2TIM at address 3. `field` is high throughout the second field and low otherwise.
- R5: The back-porch field of V2TIM, bits [19:10], gives the second field's back-porch line count directly, with no plus one. Its sync and front-porch fields are minus-one coded.
- R6: CTRL is at address 5. When CTRL bit 1 is 1, hsync is driven active-low. When CTRL bit 2 is 1, vsync is driven active-low. Otherwise each sync is active-high. A polarity change applies on the next cycle.
- R7: While CTRL bit 0 (enable) is 0, `de` and `field` are 0 and both syncs sit at their inactive level. After enable is set, the first cycle shows column 0 of line 0 of the first field, and the counters advance one pixel per cycle.
- R8: Interlaced scan is selected only when CTRL bit 3 and CTRL bit 4 are both 1. With only one of these bits set, the scan is progressive.
- R9: The status bit is set in the cycle after the first pixel of vertical sync, in every frame and in every field. `irq` equals status AND the mask bit, which is bit 0 at address 6. A masked event still sets status.
- R10: Writing 1 to bit 0 at address 7 clears status on the next cycle. Writing 0 has no effect. If a new event occurs in the same cycle as the clear, the new event wins.
- R11: Writes to addresses 0 to 4, and to the scan-mode bits, take effect after the last pixel of a frame. In interlaced scan that is the end of the second field. While the generator is disabled, such writes take effect on the next cycle.
- R12: After reset all registers are zero: `de`, `field` and `irq` are 0, and both syncs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst | input | 1 | synchronous reset, active high |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register address |
| wr_data | input | 32 | register write data |
| hsync | output | 1 | horizontal sync, polarity applied |
| vsync | output | 1 | vertical sync, polarity applied |
| de | output | 1 | data enable |
| field | output | 1 | high during the second field |
| irq | output | 1 | frame-event interrupt |

## Verification
The bench uses the default 10-bit field width. It programs small timing values: 15-pixel lines, 11-line progressive frames and 8- to 9-line interlaced fields. This lets one run reach many frame and field boundaries, pending-set transfers and vsync events. Small values also make the one-line-longer second-field back porch visible within a few hundred cycles. Mid-frame rewrites, a half-set scan-control pair, polarity flips and clears that race a masked event are each checked pixel by pixel against a behavioural model.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    localparam int unsigned RTG_CW = 10;

    localparam logic [2:0] A_ACT   = 3'd0;
    localparam logic [2:0] A_HTIM  = 3'd1;
    localparam logic [2:0] A_V1TIM = 3'd2;
    localparam logic [2:0] A_V2TIM = 3'd3;
    localparam logic [2:0] A_F2ACT = 3'd4;
    localparam logic [2:0] A_CTRL  = 3'd5;
    localparam logic [2:0] A_MASK  = 3'd6;
    localparam logic [2:0] A_STAT  = 3'd7;

    typedef struct packed {
        logic [RTG_CW-1:0] act;
        logic [RTG_CW-1:0] fp;
        logic [RTG_CW-1:0] sw;
        logic [RTG_CW-1:0] bp;
    } axis_t;

    typedef struct packed {
        axis_t h;
        axis_t v1;
        axis_t v2;
        logic  il;
    } timing_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int unsigned CW = RTG_CW,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          vs_start_i,
    output logic          en_o,
    output logic          hpl_o,
    output logic          vpl_o,
    output timing_t       pend_o,
    output logic          irq_o
);
    typedef struct packed {
        timing_t pend;
        logic    en;
        logic    hpl;
        logic    vpl;
        logic    mask;
        logic    stat;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                A_ACT: begin
                    r_d.pend.h.act  = wr_data[CW-1:0];
                    r_d.pend.v1.act = wr_data[2*CW-1:CW];
                end
                A_HTIM: begin
                    r_d.pend.h.sw = wr_data[CW-1:0];
                    r_d.pend.h.bp = wr_data[2*CW-1:CW];
                    r_d.pend.h.fp = wr_data[3*CW-1:2*CW];
                end
                A_V1TIM: begin
                    r_d.pend.v1.sw = wr_data[CW-1:0];
                    r_d.pend.v1.bp = wr_data[2*CW-1:CW];
                    r_d.pend.v1.fp = wr_data[3*CW-1:2*CW];
                end
                A_V2TIM: begin
                    r_d.pend.v2.sw = wr_data[CW-1:0];
                    r_d.pend.v2.bp = wr_data[2*CW-1:CW];
                    r_d.pend.v2.fp = wr_data[3*CW-1:2*CW];
                end
                A_F2ACT: r_d.pend.v2.act = wr_data[CW-1:0];
                A_CTRL: begin
                    r_d.en      = wr_data[0];
                    r_d.hpl     = wr_data[1];
                    r_d.vpl     = wr_data[2];
                    r_d.pend.il = wr_data[3] & wr_data[4];
                end
                A_MASK: r_d.mask = wr_data[0];
                A_STAT: if (wr_data[0]) r_d.stat = 1'b0;
                default: ;
            endcase
        end
        if (vs_start_i) r_d.stat = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign en_o   = r_q.en;
    assign hpl_o  = r_q.hpl;
    assign vpl_o  = r_q.vpl;
    assign pend_o = r_q.pend;
    assign irq_o  = r_q.stat & r_q.mask;

    a_r9_event_sets_status: assert property (@(posedge clk) disable iff (rst)
        vs_start_i |=> r_q.stat);
    a_r10_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_STAT && wr_data[0] && !vs_start_i) |=> !r_q.stat);
endmodule

// File: rtl/rtg_core.sv
module rtg_core
    import rtg_pkg::*;
#(
    parameter int unsigned CW = RTG_CW,
    localparam int unsigned TW = CW + 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    en_i,
    input  timing_t pend_i,
    output logic    de_o,
    output logic    hs_o,
    output logic    vs_o,
    output logic    fld_o,
    output logic    vs_start_o
);
    typedef struct packed {
        logic [TW-1:0] h;
        logic [TW-1:0] v;
        logic          fld;
        timing_t       act;
    } core_t;

    core_t c_d, c_q;

    logic [TW-1:0] hact, hfp, hsw, hbp, htot;
    logic [TW-1:0] vact, vfp, vsw, vbp, vtot;
    logic          h_end, v_end;

    always_comb begin
        hact = TW'(c_q.act.h.act) + 1'b1;
        hfp  = TW'(c_q.act.h.fp)  + 1'b1;
        hsw  = TW'(c_q.act.h.sw)  + 1'b1;
        hbp  = TW'(c_q.act.h.bp)  + 1'b1;
        if (c_q.fld) begin
            vact = TW'(c_q.act.v2.act) + 1'b1;
            vfp  = TW'(c_q.act.v2.fp)  + 1'b1;
            vsw  = TW'(c_q.act.v2.sw)  + 1'b1;
            vbp  = TW'(c_q.act.v2.bp);
        end else begin
            vact = TW'(c_q.act.v1.act) + 1'b1;
            vfp  = TW'(c_q.act.v1.fp)  + 1'b1;
            vsw  = TW'(c_q.act.v1.sw)  + 1'b1;
            vbp  = TW'(c_q.act.v1.bp)  + 1'b1;
        end
        htot  = hact + hfp + hsw + hbp;
        vtot  = vact + vfp + vsw + vbp;
        h_end = (c_q.h == htot - 1'b1);
        v_end = (c_q.v == vtot - 1'b1);

        c_d = c_q;
        if (!en_i) begin
            c_d.h   = '0;
            c_d.v   = '0;
            c_d.fld = 1'b0;
            c_d.act = pend_i;
        end else if (h_end) begin
            c_d.h = '0;
            if (v_end) begin
                c_d.v = '0;
                if (c_q.act.il && !c_q.fld) begin
                    c_d.fld = 1'b1;
                end else begin
                    c_d.fld = 1'b0;
                    c_d.act = pend_i;
                end
            end else begin
                c_d.v = c_q.v + 1'b1;
            end
        end else begin
            c_d.h = c_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign de_o  = en_i && (c_q.h < hact) && (c_q.v < vact);
    assign hs_o  = en_i && (c_q.h >= hact + hfp) && (c_q.h < hact + hfp + hsw);
    assign vs_o  = en_i && (c_q.v >= vact + vfp) && (c_q.v < vact + vfp + vsw);
    assign fld_o = en_i && c_q.fld;
    assign vs_start_o = en_i && (c_q.h == '0) && (c_q.v == vact + vfp);

    a_r7_off_restarts: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (c_q.h == '0 && c_q.v == '0 && !c_q.fld));
    a_r8_prog_no_second_field: assert property (@(posedge clk) disable iff (rst)
        !c_q.act.il |-> !c_q.fld);
    a_r11_working_set_holds: assert property (@(posedge clk) disable iff (rst)
        (en_i && !(h_end && v_end)) |=> $stable(c_q.act));
    a_r2_column_in_line: assert property (@(posedge clk) disable iff (rst)
        en_i |-> (c_q.h < htot));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int unsigned CW = RTG_CW,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          field,
    output logic          irq
);
    logic    en, hpl, vpl, hs_i, vs_i, vs_start;
    timing_t pend;

    rtg_regs #(.CW(CW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vs_start_i(vs_start), .en_o(en),
        .hpl_o(hpl), .vpl_o(vpl), .pend_o(pend), .irq_o(irq)
    );

    rtg_core #(.CW(CW)) u_core (
        .clk(clk), .rst(rst), .en_i(en), .pend_i(pend), .de_o(de),
        .hs_o(hs_i), .vs_o(vs_i), .fld_o(field), .vs_start_o(vs_start)
    );

    assign hsync = hs_i ^ hpl;
    assign vsync = vs_i ^ vpl;
endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, de, field, irq;

    int tests = 0, fails = 0, cyc = 0;
    bit running = 0, done = 0;
    string phase = "R12";

    always #2 clk = ~clk;

    raster_timing_gen u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
        .field(field), .irq(irq)
    );

    // behavioural model: index 0..3 h act/fp/sw/bp, 4..7 field1, 8..11 field2, 12 interlace
    int pend [13];
    int act  [13];
    int m_h, m_v, m_f, m_en, m_hp, m_vp, m_mask, m_stat;
    int e_de, e_hs, e_vs, e_fl, e_vss, e_fe, e_he, e_ve;

    task automatic decode();
        int b, va, vf, vw, vb, ht, vt;
        b  = m_f ? 8 : 4;
        va = act[b] + 1; vf = act[b+1] + 1; vw = act[b+2] + 1;
        vb = m_f ? act[11] : act[7] + 1;
        ht = act[0] + act[1] + act[2] + act[3] + 4;
        vt = va + vf + vw + vb;
        e_de  = (m_en && m_h < act[0] + 1 && m_v < va) ? 1 : 0;
        e_hs  = (m_en && m_h >= act[0] + act[1] + 2 && m_h < act[0] + act[1] + act[2] + 3) ? 1 : 0;
        e_vs  = (m_en && m_v >= va + vf && m_v < va + vf + vw) ? 1 : 0;
        e_fl  = (m_en && m_f) ? 1 : 0;
        e_vss = (m_en && m_h == 0 && m_v == va + vf) ? 1 : 0;
        e_he  = (m_h == ht - 1) ? 1 : 0;
        e_ve  = (m_v == vt - 1) ? 1 : 0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 13; i++) begin pend[i] = 0; act[i] = 0; end
            m_h = 0; m_v = 0; m_f = 0; m_en = 0; m_hp = 0; m_vp = 0;
            m_mask = 0; m_stat = 0;
        end else begin
            decode();
            if (wr_en && wr_addr == 3'd7 && wr_data[0]) m_stat = 0;
            if (e_vss) m_stat = 1;
            if (!m_en) begin
                m_h = 0; m_v = 0; m_f = 0;
                for (int i = 0; i < 13; i++) act[i] = pend[i];
            end else if (e_he) begin
                m_h = 0;
                if (e_ve) begin
                    m_v = 0;
                    if (act[12] && !m_f) m_f = 1;
                    else begin
                        m_f = 0;
                        for (int i = 0; i < 13; i++) act[i] = pend[i];
                    end
                end else m_v++;
            end else m_h++;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin pend[0] = int'(wr_data[9:0]); pend[4] = int'(wr_data[19:10]); end
                    3'd1: begin pend[2] = int'(wr_data[9:0]); pend[3] = int'(wr_data[19:10]); pend[1] = int'(wr_data[29:20]); end
                    3'd2: begin pend[6] = int'(wr_data[9:0]); pend[7] = int'(wr_data[19:10]); pend[5] = int'(wr_data[29:20]); end
                    3'd3: begin pend[10] = int'(wr_data[9:0]); pend[11] = int'(wr_data[19:10]); pend[9] = int'(wr_data[29:20]); end
                    3'd4: pend[8] = int'(wr_data[9:0]);
                    3'd5: begin
                        m_en = wr_data[0]; m_hp = wr_data[1]; m_vp = wr_data[2];
                        pend[12] = (wr_data[3] && wr_data[4]) ? 1 : 0;
                    end
                    3'd6: m_mask = wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, string sig, int a, int e);
        tests++;
        if (a != e) begin
            fails++;
            $display("FAIL %s %s in phase %s at cycle %0d: actual=%0d expected=%0d",
                     req, sig, phase, cyc, a, e);
        end
    endtask

    always @(negedge clk) begin
        if (running && !rst) begin
            decode();
            chk("R1", "de", int'(de), e_de);
            chk("R2", "hsync", int'(hsync), e_hs ^ m_hp);
            chk("R3", "vsync", int'(vsync), e_vs ^ m_vp);
            chk("R4", "field", int'(field), e_fl);
            chk("R9", "irq", int'(irq), (m_stat && m_mask) ? 1 : 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired at cycle %0d: actual=hung expected=finished", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] tim(int sw, int bp, int fp);
        return {2'b00, fp[9:0], bp[9:0], sw[9:0]};
    endfunction

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "de", int'(de), 0);
        chk("R12", "hsync", int'(hsync), 0);
        chk("R12", "vsync", int'(vsync), 0);
        chk("R12", "field", int'(field), 0);
        chk("R12", "irq", int'(irq), 0);
        running = 1;

        phase = "R7";
        wr(3'd0, {12'd0, 10'd5, 10'd7});
        wr(3'd1, tim(2, 1, 1));
        wr(3'd2, tim(1, 1, 0));
        idle(5);
        wr(3'd6, 32'd1);
        wr(3'd5, 32'd1);
        phase = "R3";
        idle(340);

        phase = "R10";
        wr(3'd7, 32'd0);
        idle(3);
        wr(3'd7, 32'd1);
        idle(20);

        phase = "R9";
        wr(3'd6, 32'd0);
        idle(200);
        wr(3'd6, 32'd1);
        idle(5);
        wr(3'd7, 32'd1);
        idle(10);

        phase = "R6";
        wr(3'd5, 32'd7);
        idle(170);
        wr(3'd5, 32'd3);
        idle(30);

        phase = "R11";
        wr(3'd1, tim(1, 2, 3));
        wr(3'd0, {12'd0, 10'd4, 10'd5});
        idle(400);

        phase = "R8";
        wr(3'd0, {12'd0, 10'd2, 10'd5});
        wr(3'd4, 32'd2);
        wr(3'd3, tim(1, 3, 0));
        wr(3'd5, 32'h9);
        idle(300);
        wr(3'd5, 32'h11);
        idle(300);

        phase = "R4 R5";
        wr(3'd5, 32'h19);
        idle(700);
        wr(3'd7, 32'd1);
        idle(300);

        phase = "R7";
        wr(3'd5, 32'h18);
        idle(50);
        wr(3'd5, 32'h1);
        idle(200);

        running = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule